// File: doc/BRIEF.md
# Bridge Error Status Capture Unit

This block collects error events raised by the engines of a bus bridge and keeps them in sticky status bits that software clears by writing ones. Three kinds of event come in as single-cycle pulses: a target abort (with a qualifier saying whether the abort counts as an error), a parity error on write data received by the bridge's target side, and a data parity error seen by the bridge's master side. Each abort pulse carries the address of the failing transfer and its direction.

When an error-qualified abort arrives and both abort enables are on, the unit records the address in an error address register and records an error type and a read/write flag in a syndrome register. Each of the two holds its own free flag. A capture clears that flag and locks the register. Software frees the register again by writing a one to the flag. A summary request output reports any status bit that is set and whose enable is on.

Software reaches the unit through a small register port with four word addresses. Reads are combinational. Writes take effect at the next clock edge.

Top module: `bridge_err_capture`

## Requirements
- R1: A pulse on `ev_tabort` sets STATUS[0] whatever the control bits hold. Writing 1 to STATUS[0] clears it, and writing 0 to it leaves it unchanged.
- R2: A pulse on `ev_tabort` with `ev_tabort_err` high sets STATUS[1], even when CTRL[2] (master-error enable) is 0. STATUS[1] clears on a write of 1.
- R3: An error-qualified abort copies `ev_addr` into ERRADDR only while SYND[4] (address free) is 1. The capture then clears SYND[4].
- R4: An error-qualified abort writes 3'b101 (non-configured bank) into SYND[2:0] only while SYND[5] (fields free) is 1. The capture then clears SYND[5].
- R5: The same capture writes SYND[3] as 1 for a read transfer (`ev_is_read`=1) and as 0 for a write transfer.
- R6: No capture of ERRADDR or of the syndrome fields takes place unless CTRL[1] (abort enable) and CTRL[2] are both 1.
- R7: A locked register keeps its content until software writes 1 to its free bit. SYND[4] and SYND[5] are freed independently, and writing 0 to them has no effect.
- R8: With CTRL[0] (parity response) at 1, a pulse on `ev_tgt_wpar` sets STATUS[2] whatever CTRL[3] holds. It sets STATUS[3] (system error signalled) and STATUS[4] (write parity error) only when CTRL[3] (write parity enable) is 1. All three bits clear on a write of 1.
- R9: With CTRL[0] at 0, pulses on `ev_tgt_wpar` and `ev_mst_par` change no status bit. With CTRL[0] at 1, a pulse on `ev_mst_par` sets STATUS[2].
- R10: When an event and a write of 1 hit the same status bit in the same cycle, the bit stays set.
- R11: `err_irq` is the OR of STATUS[0]&CTRL[1], STATUS[1]&CTRL[2], STATUS[2]&CTRL[0], and (STATUS[3] or STATUS[4])&CTRL[3]. It follows register changes in the cycle they occur.
- R12: Word addresses are 0 = CTRL, 1 = STATUS, 2 = ERRADDR (read-only), 3 = SYND. After reset, CTRL, STATUS and ERRADDR read 0 and SYND reads 0x30.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register word address |
| cfg_wdata | input | DATA_W | Register write data |
| cfg_rdata | output | DATA_W | Register read data (combinational) |
| ev_tabort | input | 1 | Target abort received pulse |
| ev_tabort_err | input | 1 | Qualifies the abort as an error |
| ev_tgt_wpar | input | 1 | Target-side write data parity error pulse |
| ev_mst_par | input | 1 | Master-side data parity error pulse |
| ev_addr | input | ADDR_W | Address of the aborted transfer |
| ev_is_read | input | 1 | Direction of the aborted transfer, 1 = read |
| err_irq | output | 1 | Summary error request |

## Verification
The first aborts arrive with all enables off and then with only one abort enable on. These cases separate status bits that ignore the enables from capture, which needs both. A chain of aborts with mixed directions then runs while the two locks are freed one at a time. It shows that the address and the syndrome lock independently, and that the direction flag comes from the capturing transfer rather than from a later one. Parity events are driven with parity response off, then with it on and the write parity enable off, then with both on. This separates the unmasked bit from the two enable-gated bits. Events that coincide with clearing writes, and changes to the enables while status stays put, show that set has priority and that the summary request is gated by the enables rather than latched.

// File: rtl/berr_pkg.sv
// Package: shared types, register offsets and bit positions of the
// bridge error capture unit. Assumes a 2-bit word address space.
package berr_pkg;

    // Register word addresses.
    localparam logic [1:0] REG_CTRL   = 2'd0;
    localparam logic [1:0] REG_STATUS = 2'd1;
    localparam logic [1:0] REG_EADDR  = 2'd2;
    localparam logic [1:0] REG_SYND   = 2'd3;

    // Status bit positions.
    localparam int ST_TABORT = 0;
    localparam int ST_MERR   = 1;
    localparam int ST_DPAR   = 2;
    localparam int ST_SSE    = 3;
    localparam int ST_WPAR   = 4;
    localparam int NUM_ST    = 5;

    // Control bit positions.
    localparam int CT_PAR_RESP = 0;
    localparam int CT_ABORT_EN = 1;
    localparam int CT_MERR_EN  = 2;
    localparam int CT_WPAR_EN  = 3;
    localparam int NUM_CT      = 4;

    // Syndrome layout.
    localparam int SY_TYPE_LSB   = 0;
    localparam int SY_TYPE_W     = 3;
    localparam int SY_RD         = 3;
    localparam int SY_ADDR_FREE  = 4;
    localparam int SY_FIELD_FREE = 5;

    // Error type code for a non-configured bank error.
    localparam logic [SY_TYPE_W-1:0] ERR_NCB = 3'b101;

    // Decoded control bits.
    typedef struct packed {
        logic wpar_en;
        logic merr_en;
        logic abort_en;
        logic par_resp;
    } ctrl_t;

endpackage

// File: rtl/berr_sticky.sv
// Module: berr_sticky
// A vector of sticky status bits. Each bit sets on its set pulse and
// clears on a write-one-to-clear strobe. When both arrive together,
// set wins. Assumes set and clr are synchronous to clk.
module berr_sticky #(
    parameter int N = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set,
    input  logic [N-1:0] clr,
    output logic [N-1:0] q
);

    genvar gi;
    generate
        for (gi = 0; gi < N; gi++) begin : g_bit
            // Purpose: one sticky bit, with set taking priority over clear.
            always_ff @(posedge clk) begin
                if (!rst_n)          q[gi] <= 1'b0;
                else if (set[gi])    q[gi] <= 1'b1;
                else if (clr[gi])    q[gi] <= 1'b0;
            end
        end
    endgenerate

    // A set request always leaves its bit set in the next cycle.
    assert_set_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (set != '0) |=> ((q & $past(set)) == $past(set)));

    // A bit only falls when a clear strobe was given for it.
    assert_w1c_only_R1: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((($past(q) & ~q) & ~$past(clr)) == '0));

endmodule

// File: rtl/berr_capture.sv
// Module: berr_capture
// Error address and syndrome capture, each with its own lock. A capture
// happens on `fire` only while that part is free, and then locks it.
// Software frees a part by pulsing its free_set bit. Assumes that
// `fire` is already gated by the enables.
module berr_capture
    import berr_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 fire,
    input  logic [ADDR_W-1:0]    ev_addr,
    input  logic                 ev_is_read,
    input  logic                 free_addr_set,
    input  logic                 free_field_set,
    output logic [ADDR_W-1:0]    err_addr,
    output logic [SY_TYPE_W-1:0] err_type,
    output logic                 err_rd,
    output logic                 addr_free,
    output logic                 field_free
);

    logic cap_addr;
    logic cap_field;

    // Purpose: decide which parts take this event.
    always_comb begin
        cap_addr  = fire && addr_free;
        cap_field = fire && field_free;
    end

    // Purpose: the address register and its lock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_addr  <= '0;
            addr_free <= 1'b1;
        end else if (cap_addr) begin
            err_addr  <= ev_addr;
            addr_free <= 1'b0;
        end else if (free_addr_set) begin
            addr_free <= 1'b1;
        end
    end

    // Purpose: the syndrome fields and their lock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_type   <= '0;
            err_rd     <= 1'b0;
            field_free <= 1'b1;
        end else if (cap_field) begin
            err_type   <= ERR_NCB;
            err_rd     <= ev_is_read;
            field_free <= 1'b0;
        end else if (free_field_set) begin
            field_free <= 1'b1;
        end
    end

    // A capture takes the event address and locks the address register.
    assert_addr_capture_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && addr_free) |=> (!addr_free && err_addr == $past(ev_addr)));

    // A capture writes the bank-error code and the direction.
    assert_type_code_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && field_free) |=> (err_type == ERR_NCB && err_rd == $past(ev_is_read)));

    // A locked address stays until software frees it.
    assert_addr_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!addr_free && !free_addr_set) |=> ($stable(err_addr) && !addr_free));

    // Locked fields stay until software frees them.
    assert_field_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!field_free && !free_field_set) |=> ($stable(err_type) && $stable(err_rd) && !field_free));

endmodule

// File: rtl/berr_qual.sv
// Module: berr_qual
// Turns raw event pulses into set requests for the status bits and a
// capture request, according to the control bits. It also forms the
// summary request from the status and the enables. Purely combinational.
module berr_qual
    import berr_pkg::*;
(
    input  ctrl_t             ctrl,
    input  logic              ev_tabort,
    input  logic              ev_tabort_err,
    input  logic              ev_tgt_wpar,
    input  logic              ev_mst_par,
    input  logic [NUM_ST-1:0] status,
    output logic [NUM_ST-1:0] st_set,
    output logic              cap_fire,
    output logic              irq
);

    logic abort_err;
    logic tgt_par;
    logic mst_par;

    // Purpose: qualify the raw events. Parity response masks parity events.
    always_comb begin
        abort_err = ev_tabort && ev_tabort_err;
        tgt_par   = ev_tgt_wpar && ctrl.par_resp;
        mst_par   = ev_mst_par && ctrl.par_resp;
    end

    // Purpose: map the qualified events onto status set requests.
    always_comb begin
        st_set            = '0;
        st_set[ST_TABORT] = ev_tabort;
        st_set[ST_MERR]   = abort_err;
        st_set[ST_DPAR]   = tgt_par || mst_par;
        st_set[ST_SSE]    = tgt_par && ctrl.wpar_en;
        st_set[ST_WPAR]   = tgt_par && ctrl.wpar_en;
    end

    // Purpose: capture only when both abort enables are on.
    always_comb begin
        cap_fire = abort_err && ctrl.abort_en && ctrl.merr_en;
    end

    // Purpose: summary request from the set and enabled status bits.
    always_comb begin
        irq = (status[ST_TABORT] && ctrl.abort_en)
           || (status[ST_MERR]   && ctrl.merr_en)
           || (status[ST_DPAR]   && ctrl.par_resp)
           || ((status[ST_SSE] || status[ST_WPAR]) && ctrl.wpar_en);
    end

endmodule

// File: rtl/bridge_err_capture.sv
// Module: bridge_err_capture (top)
// Bridge error status capture unit: the control register, the sticky
// status bits, the locked error address and syndrome, and the read
// mux. Assumes DATA_W >= ADDR_W and DATA_W >= 6.
module bridge_err_capture
    import berr_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic [1:0]        cfg_addr,
    input  logic [DATA_W-1:0] cfg_wdata,
    output logic [DATA_W-1:0] cfg_rdata,
    input  logic              ev_tabort,
    input  logic              ev_tabort_err,
    input  logic              ev_tgt_wpar,
    input  logic              ev_mst_par,
    input  logic [ADDR_W-1:0] ev_addr,
    input  logic              ev_is_read,
    output logic              err_irq
);

    localparam int SYND_W = SY_FIELD_FREE + 1;

    ctrl_t                 ctrl_q;
    logic [NUM_ST-1:0]     status_q;
    logic [NUM_ST-1:0]     st_set;
    logic [NUM_ST-1:0]     st_clr;
    logic                  cap_fire;
    logic                  wr_ctrl;
    logic                  wr_status;
    logic                  wr_synd;
    logic                  free_addr_set;
    logic                  free_field_set;
    logic [ADDR_W-1:0]     err_addr;
    logic [SY_TYPE_W-1:0]  err_type;
    logic                  err_rd;
    logic                  addr_free;
    logic                  field_free;
    logic [SYND_W-1:0]     synd_word;

    // Purpose: decode register write strobes.
    always_comb begin
        wr_ctrl        = cfg_wr && (cfg_addr == REG_CTRL);
        wr_status      = cfg_wr && (cfg_addr == REG_STATUS);
        wr_synd        = cfg_wr && (cfg_addr == REG_SYND);
        st_clr         = wr_status ? cfg_wdata[NUM_ST-1:0] : '0;
        free_addr_set  = wr_synd && cfg_wdata[SY_ADDR_FREE];
        free_field_set = wr_synd && cfg_wdata[SY_FIELD_FREE];
    end

    // Purpose: the control register.
    always_ff @(posedge clk) begin
        if (!rst_n)       ctrl_q <= '0;
        else if (wr_ctrl) ctrl_q <= ctrl_t'(cfg_wdata[NUM_CT-1:0]);
    end

    berr_qual u_qual (
        .ctrl          (ctrl_q),
        .ev_tabort     (ev_tabort),
        .ev_tabort_err (ev_tabort_err),
        .ev_tgt_wpar   (ev_tgt_wpar),
        .ev_mst_par    (ev_mst_par),
        .status        (status_q),
        .st_set        (st_set),
        .cap_fire      (cap_fire),
        .irq           (err_irq)
    );

    berr_sticky #(.N(NUM_ST)) u_status (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (st_set),
        .clr   (st_clr),
        .q     (status_q)
    );

    berr_capture #(.ADDR_W(ADDR_W)) u_capture (
        .clk            (clk),
        .rst_n          (rst_n),
        .fire           (cap_fire),
        .ev_addr        (ev_addr),
        .ev_is_read     (ev_is_read),
        .free_addr_set  (free_addr_set),
        .free_field_set (free_field_set),
        .err_addr       (err_addr),
        .err_type       (err_type),
        .err_rd         (err_rd),
        .addr_free      (addr_free),
        .field_free     (field_free)
    );

    // Purpose: assemble the syndrome word.
    always_comb begin
        synd_word = {field_free, addr_free, err_rd, err_type};
    end

    // Purpose: combinational register read mux.
    always_comb begin
        case (cfg_addr)
            REG_CTRL:   cfg_rdata = DATA_W'(ctrl_q);
            REG_STATUS: cfg_rdata = DATA_W'(status_q);
            REG_EADDR:  cfg_rdata = DATA_W'(err_addr);
            default:    cfg_rdata = DATA_W'(synd_word);
        endcase
    end

    // An abort without both enables never moves the captured address.
    assert_no_capture_gated_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_tabort && ev_tabort_err && !(ctrl_q.abort_en && ctrl_q.merr_en))
        |=> ($stable(err_addr) && $stable(err_type)));

    // The summary request needs some status bit to be set.
    assert_irq_needs_status_R11: assert property (@(posedge clk) disable iff (!rst_n)
        err_irq |-> (status_q != '0));

    // An abort pulse always sets the abort status bit.
    assert_tabort_sets_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ev_tabort |=> status_q[ST_TABORT]);

    // With parity response off, parity events set nothing.
    assert_par_masked_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_q.par_resp && !ev_tabort && !wr_status) |=> $stable(status_q));

endmodule

// File: tb/test_bridge_err_capture.sv
module test_bridge_err_capture;

    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W = 32;
    localparam int DATA_W = 32;
    localparam int WATCHDOG = 20000;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cfg_wr = 1'b0;
    logic [1:0]        cfg_addr = '0;
    logic [DATA_W-1:0] cfg_wdata = '0;
    logic [DATA_W-1:0] cfg_rdata;
    logic              ev_tabort = 1'b0;
    logic              ev_tabort_err = 1'b0;
    logic              ev_tgt_wpar = 1'b0;
    logic              ev_mst_par = 1'b0;
    logic [ADDR_W-1:0] ev_addr = '0;
    logic              ev_is_read = 1'b0;
    logic              err_irq;

    int checks = 0;
    int failures = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bridge_err_capture #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_bridge_err_capture (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .ev_tabort(ev_tabort),
        .ev_tabort_err(ev_tabort_err), .ev_tgt_wpar(ev_tgt_wpar),
        .ev_mst_par(ev_mst_par), .ev_addr(ev_addr), .ev_is_read(ev_is_read),
        .err_irq(err_irq)
    );

    task automatic check(input string req, input string what,
                         input logic [DATA_W-1:0] act, input logic [DATA_W-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    // Read a register between edges and compare.
    task automatic rd(input logic [1:0] a, input logic [DATA_W-1:0] exp,
                      input string req, input string what);
        cfg_addr = a;
        #1;
        check(req, what, cfg_rdata, exp);
    endtask

    task automatic chk_irq(input logic exp, input string req);
        check(req, "err_irq", {31'd0, err_irq}, {31'd0, exp});
    endtask

    task automatic wr(input logic [1:0] a, input logic [DATA_W-1:0] d);
        cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_wr = 1'b0; cfg_wdata = '0;
    endtask

    task automatic abort(input logic err, input logic [ADDR_W-1:0] a, input logic rd_dir);
        ev_tabort = 1'b1; ev_tabort_err = err; ev_addr = a; ev_is_read = rd_dir;
        @(negedge clk);
        ev_tabort = 1'b0; ev_tabort_err = 1'b0; ev_addr = '0; ev_is_read = 1'b0;
    endtask

    task automatic par(input logic tgt, input logic mst);
        ev_tgt_wpar = tgt; ev_mst_par = mst;
        @(negedge clk);
        ev_tgt_wpar = 1'b0; ev_mst_par = 1'b0;
    endtask

    task automatic t_reset;
        rd(2'd0, 32'h0,  "R12", "ctrl after reset");
        rd(2'd1, 32'h0,  "R12", "status after reset");
        rd(2'd2, 32'h0,  "R12", "erraddr after reset");
        rd(2'd3, 32'h30, "R12", "synd after reset");
        chk_irq(1'b0, "R12");
    endtask

    task automatic t_abort_no_enable;
        abort(1'b1, 32'hA000_0010, 1'b1);
        rd(2'd1, 32'h03, "R1", "abort and master-error bits with enables off (R2)");
        rd(2'd2, 32'h0,  "R6", "no address capture with enables off");
        rd(2'd3, 32'h30, "R6", "no syndrome capture with enables off");
        chk_irq(1'b0, "R11");
    endtask

    task automatic t_w1c;
        wr(2'd1, 32'h01);
        rd(2'd1, 32'h02, "R1", "write 1 clears abort bit only");
        wr(2'd1, 32'h00);
        rd(2'd1, 32'h02, "R2", "write 0 leaves master-error bit");
        wr(2'd1, 32'h02);
        rd(2'd1, 32'h00, "R2", "write 1 clears master-error bit");
    endtask

    task automatic t_capture;
        wr(2'd0, 32'h06);
        abort(1'b1, 32'h1234_5678, 1'b1);
        rd(2'd2, 32'h1234_5678, "R3", "address captured");
        rd(2'd3, 32'h0D, "R4", "type 101, read flag, both locked (R5)");
        chk_irq(1'b1, "R11");
    endtask

    task automatic t_lock;
        abort(1'b1, 32'h5555_0000, 1'b0);
        rd(2'd2, 32'h1234_5678, "R7", "locked address holds");
        rd(2'd3, 32'h0D, "R7", "locked syndrome holds");
        wr(2'd3, 32'h10);
        rd(2'd3, 32'h1D, "R7", "address freed alone");
        abort(1'b1, 32'h0000_ABCD, 1'b0);
        rd(2'd2, 32'h0000_ABCD, "R3", "recapture after free");
        rd(2'd3, 32'h0D, "R7", "fields still locked keep read flag");
        wr(2'd3, 32'h20);
        rd(2'd3, 32'h2D, "R7", "fields freed alone");
        abort(1'b1, 32'h0000_7777, 1'b0);
        rd(2'd2, 32'h0000_ABCD, "R3", "address locked, no capture");
        rd(2'd3, 32'h05, "R5", "write direction recorded as 0");
        wr(2'd3, 32'h00);
        rd(2'd3, 32'h05, "R7", "writing 0 frees nothing");
        wr(2'd3, 32'h30);
        wr(2'd0, 32'h02);
        abort(1'b1, 32'h0000_9999, 1'b1);
        rd(2'd2, 32'h0000_ABCD, "R6", "one enable is not enough");
        rd(2'd3, 32'h35, "R6", "syndrome untouched with one enable");
        wr(2'd1, 32'h1F);
        rd(2'd1, 32'h00, "R1", "all status cleared");
    endtask

    task automatic t_parity_masked;
        wr(2'd0, 32'h0E);
        par(1'b1, 1'b1);
        rd(2'd1, 32'h00, "R9", "parity events ignored with response off");
        chk_irq(1'b0, "R9");
    endtask

    task automatic t_parity;
        wr(2'd0, 32'h01);
        par(1'b1, 1'b0);
        rd(2'd1, 32'h04, "R8", "target parity without write parity enable");
        chk_irq(1'b1, "R11");
        wr(2'd1, 32'h04);
        wr(2'd0, 32'h09);
        par(1'b1, 1'b0);
        rd(2'd1, 32'h1C, "R8", "target parity with write parity enable");
        wr(2'd1, 32'h1C);
        rd(2'd1, 32'h00, "R8", "parity bits cleared");
        par(1'b0, 1'b1);
        rd(2'd1, 32'h04, "R9", "master parity sets data parity bit");
        wr(2'd1, 32'h04);
    endtask

    task automatic t_collide;
        wr(2'd0, 32'h01);
        par(1'b0, 1'b1);
        ev_mst_par = 1'b1;
        wr(2'd1, 32'h04);
        ev_mst_par = 1'b0;
        rd(2'd1, 32'h04, "R10", "parity event beats clear");
        ev_tabort = 1'b1;
        wr(2'd1, 32'h05);
        ev_tabort = 1'b0;
        rd(2'd1, 32'h01, "R10", "abort event beats clear");
        wr(2'd1, 32'h1F);
    endtask

    task automatic t_irq;
        wr(2'd0, 32'h01);
        par(1'b0, 1'b1);
        chk_irq(1'b1, "R11");
        wr(2'd0, 32'h00);
        chk_irq(1'b0, "R11");
        rd(2'd1, 32'h04, "R11", "status kept while gated off");
        abort(1'b0, 32'h0, 1'b0);
        chk_irq(1'b0, "R11");
        wr(2'd0, 32'h02);
        chk_irq(1'b1, "R11");
        rd(2'd1, 32'h05, "R2", "unqualified abort leaves master-error clear");
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_abort_no_enable;
        t_w1c;
        t_capture;
        t_lock;
        t_parity_masked;
        t_parity;
        t_collide;
        t_irq;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule